// File: doc/BRIEF.md
# Configuration transaction controller

The block gives software a three-register window for reaching numbered configuration functions on a board site and device. Software loads an operand into the data register, then writes a control word that names the target and sets a start bit. One clock cycle later the transaction is done. The status register then reports completion and, for an illegal target, an error. A successful read leaves its result in the data register.

Behind the window sit a small oscillator table and a fixed set of sensor readings. The oscillator table holds six main-board entries and a parameterised number of daughter-board entries, all of which can be read and written. The sensor readings are read-only. A halt request and a restart request leave the block as one-cycle pulses. Two other functions, the video source select and the display-mode select, are accepted and have no effect. Reads are combinational from the byte offset on the bus. Writes take effect at the clock edge on which the write strobe is sampled.

Top module: `cfg_xact_ctrl`

## Requirements
- R1: After reset the data, control and status registers read 0 and both request pulses are low. The oscillator table holds its reset values.
- R2: A write to the control register at offset 0xA4 stores the word without bit 31 (start) and bits 19:18, which always read 0. Field positions are: bit 30 write (0 = read), bits 29:26 channel, 25:20 function, 17:16 site, 15:12 position and 11:0 device.
- R3: The status register at offset 0xA8 holds bit 0 complete and bit 1 error. A control write with start set makes bit 0 read 1 on a bus read one cycle later. Bit 1 is set at the same time when the transaction fails. A direct write to status keeps only bits 1:0.
- R4: A transaction fails when the channel is nonzero, when the position is nonzero, or when the site is not 0 (main board) or 1 (daughter board).
- R5: Function 1 reads an oscillator. On site 0, devices 0 to 5 reset to 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000. On site 1, devices below DB_OSC_N reset to DB_OSC_INIT (the default is 30000000 and 45000000). Any other device fails. A successful read writes the value into the data register at offset 0xA0.
- R6: Function 1 with the write bit set stores the current data register value into the addressed oscillator entry. A later read of that entry returns the stored value.
- R7: Function 2 reads a voltage. Site 0 device 0 returns 3300000. On site 1, a device below DB_SENS_N returns DB_SENS_VAL (the default is 900000, 1000000 and 1800000). Every other device fails, and every write to function 2 fails.
- R8: Writes to functions 7, 8, 9 and 11 succeed only on site 0 device 0. Function 8 raises halt_req and function 9 raises restart_req, each for exactly one cycle starting with the completion cycle. Functions 7 and 11 have no effect. Any other combination fails and produces no pulse, and so does a read of these functions.
- R9: In the cycle a transaction completes, its result takes priority: a bus write to the data or status register in that same cycle is dropped.
- R10: A failed read leaves the data register unchanged.
- R11: Reads of any other offset return 0, and writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| halt_req | output | 1 | One-cycle halt request |
| restart_req | output | 1 | One-cycle restart request |

## Verification
A transaction completes in the cycle after its control write. A bus write to the data or status register can therefore land on the same clock edge as the completion. The bench provokes this by issuing a status clear, or a data write, in the cycle straight after a start. It then judges the result against the rule that the transaction wins: status shows the transaction's own complete and error bits, and data holds the read result or, after a failed read, the value it had before the dropped write.

// File: rtl/cfg_xact_pkg.sv
package cfg_xact_pkg;

  localparam int unsigned REG_W    = 32;
  localparam int unsigned MB_OSC_N = 6;

  typedef struct packed {
    logic        start;
    logic        wr;
    logic [3:0]  chan;
    logic [5:0]  func;
    logic [1:0]  rsvd;
    logic [1:0]  site;
    logic [3:0]  pos;
    logic [11:0] dev;
  } ctrl_t;

  localparam logic [REG_W-1:0] CTRL_KEEP = 32'h7FF3_FFFF;

  localparam logic [5:0] FN_OSC      = 6'd1;
  localparam logic [5:0] FN_VOLT     = 6'd2;
  localparam logic [5:0] FN_VIDSEL   = 6'd7;
  localparam logic [5:0] FN_HALT     = 6'd8;
  localparam logic [5:0] FN_RESTART  = 6'd9;
  localparam logic [5:0] FN_DISPMODE = 6'd11;

  localparam logic [1:0] SITE_MAIN = 2'd0;
  localparam logic [1:0] SITE_DTR  = 2'd1;

  localparam logic [REG_W-1:0] MAIN_VOLT = 32'd3300000;

  function automatic logic [REG_W-1:0] main_osc_reset(int unsigned idx);
    case (idx)
      0:       return 32'd50000000;
      1:       return 32'd23750000;
      default: return 32'd24000000;
    endcase
  endfunction

endpackage

// File: rtl/cfg_xact_decode.sv
module cfg_xact_decode
  import cfg_xact_pkg::*;
#(
  parameter int unsigned DB_OSC_N  = 2,
  parameter int unsigned DB_SENS_N = 3,
  parameter logic [DB_SENS_N*REG_W-1:0] DB_SENS_VAL = {32'd1800000, 32'd1000000, 32'd900000},
  parameter int unsigned IDX_W = 3
) (
  input  ctrl_t             job,
  output logic              ok,
  output logic              osc_hit,
  output logic [IDX_W-1:0]  osc_idx,
  output logic [REG_W-1:0]  const_val,
  output logic              halt,
  output logic              restart
);

  logic target_ok;
  logic on_main;
  logic on_dtr;
  logic main_dev0;
  int   dev_i;

  always_comb begin
    dev_i     = int'(job.dev);
    on_main   = (job.site == SITE_MAIN);
    on_dtr    = (job.site == SITE_DTR);
    main_dev0 = on_main && (job.dev == '0);
    target_ok = (job.chan == '0) && (job.pos == '0) && (on_main || on_dtr);
  end

  always_comb begin
    ok        = 1'b0;
    osc_hit   = 1'b0;
    osc_idx   = '0;
    const_val = '0;
    halt      = 1'b0;
    restart   = 1'b0;
    if (target_ok) begin
      case (job.func)
        FN_OSC: begin
          if (on_main && dev_i < int'(MB_OSC_N)) begin
            ok      = 1'b1;
            osc_hit = 1'b1;
            osc_idx = IDX_W'(dev_i);
          end else if (on_dtr && dev_i < int'(DB_OSC_N)) begin
            ok      = 1'b1;
            osc_hit = 1'b1;
            osc_idx = IDX_W'(dev_i + int'(MB_OSC_N));
          end
        end
        FN_VOLT: begin
          if (!job.wr) begin
            if (main_dev0) begin
              ok        = 1'b1;
              const_val = MAIN_VOLT;
            end else if (on_dtr) begin
              for (int s = 0; s < int'(DB_SENS_N); s++) begin
                if (dev_i == s) begin
                  ok        = 1'b1;
                  const_val = DB_SENS_VAL[s*REG_W +: REG_W];
                end
              end
            end
          end
        end
        FN_VIDSEL, FN_DISPMODE: begin
          ok = job.wr && main_dev0;
        end
        FN_HALT: begin
          ok   = job.wr && main_dev0;
          halt = job.wr && main_dev0;
        end
        FN_RESTART: begin
          ok      = job.wr && main_dev0;
          restart = job.wr && main_dev0;
        end
        default: ok = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/cfg_xact_osc_table.sv
module cfg_xact_osc_table
  import cfg_xact_pkg::*;
#(
  parameter int unsigned DB_OSC_N = 2,
  parameter logic [DB_OSC_N*REG_W-1:0] DB_OSC_INIT = {32'd45000000, 32'd30000000},
  parameter int unsigned IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata
);

  localparam int unsigned ENTRIES = MB_OSC_N + DB_OSC_N;

  logic [REG_W-1:0] entry_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic             en;
    logic [REG_W-1:0] rst_val;

    if (g < MB_OSC_N) begin : g_main
      assign rst_val = main_osc_reset(g);
    end else begin : g_dtr
      assign rst_val = DB_OSC_INIT[(g-MB_OSC_N)*REG_W +: REG_W];
    end

    assign en = we && (int'(idx) == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  entry_q[g] <= rst_val;
      else if (en) entry_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < int'(ENTRIES); i++) begin
      if (int'(idx) == i) rdata = entry_q[i];
    end
  end

endmodule

// File: rtl/cfg_xact_ctrl.sv
module cfg_xact_ctrl
  import cfg_xact_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DB_OSC_N  = 2,
  parameter logic [DB_OSC_N*REG_W-1:0] DB_OSC_INIT = {32'd45000000, 32'd30000000},
  parameter int unsigned DB_SENS_N = 3,
  parameter logic [DB_SENS_N*REG_W-1:0] DB_SENS_VAL = {32'd1800000, 32'd1000000, 32'd900000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              halt_req,
  output logic              restart_req
);

  localparam int unsigned ENTRIES = MB_OSC_N + DB_OSC_N;
  localparam int unsigned IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(8'hA0);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(8'hA4);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8'hA8);

  logic [REG_W-1:0] data_q, data_d;
  ctrl_t            ctrl_q, ctrl_d;
  logic [1:0]       status_q, status_d;
  logic             pend_q, pend_d;
  logic             halt_q, halt_d;
  logic             restart_q, restart_d;
  logic             data_en, ctrl_en, status_en;

  logic             dec_ok, dec_osc_hit, dec_halt, dec_restart;
  logic [IDX_W-1:0] dec_idx;
  logic [REG_W-1:0] dec_const, osc_rdata, rd_result;
  logic             osc_we;

  cfg_xact_decode #(
    .DB_OSC_N   (DB_OSC_N),
    .DB_SENS_N  (DB_SENS_N),
    .DB_SENS_VAL(DB_SENS_VAL),
    .IDX_W      (IDX_W)
  ) u_decode (
    .job      (ctrl_q),
    .ok       (dec_ok),
    .osc_hit  (dec_osc_hit),
    .osc_idx  (dec_idx),
    .const_val(dec_const),
    .halt     (dec_halt),
    .restart  (dec_restart)
  );

  cfg_xact_osc_table #(
    .DB_OSC_N   (DB_OSC_N),
    .DB_OSC_INIT(DB_OSC_INIT),
    .IDX_W      (IDX_W)
  ) u_osc (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (osc_we),
    .idx  (dec_idx),
    .wdata(data_q),
    .rdata(osc_rdata)
  );

  assign rd_result = dec_osc_hit ? osc_rdata : dec_const;
  assign osc_we    = pend_q && ctrl_q.wr && dec_ok && dec_osc_hit;

  // next state: a completing transaction outranks bus writes to data/status
  always_comb begin
    data_d    = data_q;
    data_en   = 1'b0;
    status_d  = status_q;
    status_en = 1'b0;
    ctrl_d    = ctrl_q;
    ctrl_en   = 1'b0;
    pend_d    = 1'b0;
    halt_d    = 1'b0;
    restart_d = 1'b0;

    if (bus_wr) begin
      case (bus_addr)
        OFF_DATA: begin
          data_d  = bus_wdata;
          data_en = 1'b1;
        end
        OFF_CTRL: begin
          ctrl_d  = ctrl_t'(bus_wdata & CTRL_KEEP);
          ctrl_en = 1'b1;
          pend_d  = bus_wdata[31];
        end
        OFF_STAT: begin
          status_d  = bus_wdata[1:0];
          status_en = 1'b1;
        end
        default: ;
      endcase
    end

    if (pend_q) begin
      status_d  = {~dec_ok, 1'b1};
      status_en = 1'b1;
      data_en   = !ctrl_q.wr && dec_ok;
      data_d    = rd_result;
      halt_d    = dec_halt;
      restart_d = dec_restart;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= '0;
      ctrl_q    <= '0;
      status_q  <= '0;
      pend_q    <= 1'b0;
      halt_q    <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      if (data_en)   data_q   <= data_d;
      if (ctrl_en)   ctrl_q   <= ctrl_d;
      if (status_en) status_q <= status_d;
      pend_q    <= pend_d;
      halt_q    <= halt_d;
      restart_q <= restart_d;
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_DATA: bus_rdata = data_q;
      OFF_CTRL: bus_rdata = ctrl_q;
      OFF_STAT: bus_rdata = {30'd0, status_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign halt_req    = halt_q;
  assign restart_req = restart_q;

endmodule

// File: rtl/cfg_xact_ctrl_chk.sv
module cfg_xact_ctrl_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              halt_req,
  input logic              restart_req,
  input logic [1:0]        status_q
);

  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(8'hA4);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8'hA8);

  logic start_wr;
  assign start_wr = bus_wr && (bus_addr == OFF_CTRL) && bus_wdata[31];

  a_r2_ctrl_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_CTRL) |-> (bus_rdata[31] == 1'b0 && bus_rdata[19:18] == 2'b00));

  a_r3_status_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_STAT) |-> (bus_rdata[31:2] == '0));

  a_r3_complete_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |-> ##2 status_q[0]);

  a_r4_bad_channel_errs: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && bus_wdata[29:26] != 4'd0) |-> ##2 (status_q == 2'b11));

  a_r8_halt_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> !halt_req);

  a_r8_restart_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !restart_req);

  a_r8_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_req && restart_req));

endmodule

bind cfg_xact_ctrl cfg_xact_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .halt_req   (halt_req),
  .restart_req(restart_req),
  .status_q   (status_q)
);

// File: tb/cfg_xact_ctrl_tb.sv
module cfg_xact_ctrl_tb;

  localparam logic [7:0] A_DATA = 8'hA0;
  localparam logic [7:0] A_CTRL = 8'hA4;
  localparam logic [7:0] A_STAT = 8'hA8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        halt_req, restart_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_xact_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .halt_req(halt_req), .restart_req(restart_req)
  );

  function automatic logic [31:0] mk(bit st, bit wr, int chan, int fn, int site, int pos, int dev);
    return {st, wr, 4'(chan), 6'(fn), 2'b00, 2'(site), 4'(pos), 12'(dev)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // start a transaction and wait until its result is visible
  task automatic run(logic [31:0] c);
    wr(A_CTRL, c);
    @(negedge clk);
  endtask

  task automatic xact_expect(string req, logic [31:0] c, logic [1:0] st, logic [31:0] dexp);
    logic [31:0] v;
    run(c);
    rd(A_STAT, v); chk({req, " status"}, v, {30'd0, st});
    rd(A_DATA, v); chk({req, " data"}, v, dexp);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_DATA, v); chk("R1 data", v, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_STAT, v); chk("R1 status", v, 0);
    chk("R1 pulses", {30'd0, halt_req, restart_req}, 0);
  endtask

  task automatic t_ctrl_fields();
    logic [31:0] v;
    wr(A_CTRL, 32'h7FFF_FFFF);
    rd(A_CTRL, v); chk("R2 masked", v, 32'h7FF3_FFFF);
    rd(A_STAT, v); chk("R3 no start no status", v, 0);
    run(32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R2 start reads zero", v, 32'h7FF3_FFFF);
    rd(A_STAT, v); chk("R4 all ones fails", v, 3);
  endtask

  task automatic t_main_osc_read();
    logic [31:0] exp [6] = '{32'd50000000, 32'd23750000, 32'd24000000,
                             32'd24000000, 32'd24000000, 32'd24000000};
    for (int i = 0; i < 6; i++) xact_expect("R5 main osc", mk(1,0,0,1,0,0,i), 2'b01, exp[i]);
    xact_expect("R5 main osc out of range", mk(1,0,0,1,0,0,6), 2'b11, exp[5]);
  endtask

  task automatic t_dtr_osc_read();
    xact_expect("R5 dtr osc0", mk(1,0,0,1,1,0,0), 2'b01, 32'd30000000);
    xact_expect("R5 dtr osc1", mk(1,0,0,1,1,0,1), 2'b01, 32'd45000000);
    xact_expect("R10 dtr osc2 fail keeps data", mk(1,0,0,1,1,0,2), 2'b11, 32'd45000000);
  endtask

  task automatic t_osc_write();
    wr(A_DATA, 32'h1234_5678);
    xact_expect("R6 main osc3 write", mk(1,1,0,1,0,0,3), 2'b01, 32'h1234_5678);
    wr(A_DATA, 32'h0);
    xact_expect("R6 main osc3 readback", mk(1,0,0,1,0,0,3), 2'b01, 32'h1234_5678);
    wr(A_DATA, 32'hCAFE_0001);
    xact_expect("R6 dtr osc1 write", mk(1,1,0,1,1,0,1), 2'b01, 32'hCAFE_0001);
    wr(A_DATA, 32'h0);
    xact_expect("R6 dtr osc1 readback", mk(1,0,0,1,1,0,1), 2'b01, 32'hCAFE_0001);
    xact_expect("R6 neighbour untouched", mk(1,0,0,1,0,0,2), 2'b01, 32'd24000000);
  endtask

  task automatic t_volt();
    xact_expect("R7 main volt", mk(1,0,0,2,0,0,0), 2'b01, 32'd3300000);
    xact_expect("R7 main dev1 fail", mk(1,0,0,2,0,0,1), 2'b11, 32'd3300000);
    xact_expect("R7 dtr sensor2", mk(1,0,0,2,1,0,2), 2'b01, 32'd1800000);
    xact_expect("R7 dtr sensor0", mk(1,0,0,2,1,0,0), 2'b01, 32'd900000);
    xact_expect("R7 dtr sensor3 fail", mk(1,0,0,2,1,0,3), 2'b11, 32'd900000);
    xact_expect("R7 volt write fail", mk(1,1,0,2,0,0,0), 2'b11, 32'd900000);
  endtask

  task automatic t_illegal();
    xact_expect("R4 channel", mk(1,0,1,1,0,0,0), 2'b11, 32'd900000);
    xact_expect("R4 position", mk(1,0,0,1,0,2,0), 2'b11, 32'd900000);
    xact_expect("R4 site2", mk(1,0,0,1,2,0,0), 2'b11, 32'd900000);
    xact_expect("R4 site3", mk(1,0,0,1,3,0,0), 2'b11, 32'd900000);
  endtask

  task automatic t_status_write();
    logic [31:0] v;
    wr(A_STAT, 32'hFFFF_FFFC);
    rd(A_STAT, v); chk("R3 status write masked", v, 0);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R3 status write ones", v, 3);
  endtask

  task automatic pulse_test(string req, logic [31:0] c, bit ex_h, bit ex_r, logic [1:0] st);
    logic [31:0] v;
    wr(A_CTRL, c);
    chk({req, " before"}, {30'd0, halt_req, restart_req}, 0);
    @(negedge clk);
    chk({req, " pulse"}, {30'd0, halt_req, restart_req}, {30'd0, ex_h, ex_r});
    rd(A_STAT, v); chk({req, " status"}, v, {30'd0, st});
    @(negedge clk);
    chk({req, " after"}, {30'd0, halt_req, restart_req}, 0);
  endtask

  task automatic t_actions();
    pulse_test("R8 vidsel", mk(1,1,0,7,0,0,0), 0, 0, 2'b01);
    pulse_test("R8 dispmode", mk(1,1,0,11,0,0,0), 0, 0, 2'b01);
    pulse_test("R8 halt", mk(1,1,0,8,0,0,0), 1, 0, 2'b01);
    pulse_test("R8 restart", mk(1,1,0,9,0,0,0), 0, 1, 2'b01);
    pulse_test("R8 halt dev1", mk(1,1,0,8,0,0,1), 0, 0, 2'b11);
    pulse_test("R8 restart site1", mk(1,1,0,9,1,0,0), 0, 0, 2'b11);
    pulse_test("R8 halt read", mk(1,0,0,8,0,0,0), 0, 0, 2'b11);
    pulse_test("R8 other function", mk(1,1,0,5,0,0,0), 0, 0, 2'b11);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    wr(A_CTRL, mk(1,0,0,1,0,0,1));
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R9 status write dropped", v, 1);
    rd(A_DATA, v); chk("R9 read result kept", v, 32'd23750000);
    wr(A_CTRL, mk(1,0,0,1,0,0,9));
    wr(A_DATA, 32'hDEAD_BEEF);
    rd(A_STAT, v); chk("R9 failed read status", v, 3);
    rd(A_DATA, v); chk("R9 data write dropped", v, 32'd23750000);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'hAC, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R11 unmapped read", v, 0);
    rd(8'hAC, v); chk("R11 unmapped AC read", v, 0);
    rd(A_DATA, v); chk("R11 data untouched", v, 32'd23750000);
    rd(A_STAT, v); chk("R11 status untouched", v, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_fields();
    t_main_osc_read();
    t_dtr_osc_read();
    t_osc_write();
    t_volt();
    t_illegal();
    t_status_write();
    t_actions();
    t_collision();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule